// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block holds in-flight instructions of an out-of-order core in program order and retires them in that same order. At dispatch the front end asks for a slot. The grant comes only when a reservation station has also reported itself free and the ring is not full. The granted slot number becomes the instruction's destination tag. A per-register rename table records which tag will produce each architectural register last, so later instructions can name the pending producer instead of a stale value.

Results come back over a common data bus as a tag, a value and a misprediction flag. The matching slot captures them and is marked complete. Retirement looks only at the oldest slot:
- A completed arithmetic entry writes the register file.
- A completed store writes memory.
- A correctly predicted branch simply retires.
- A mispredicted branch wipes every slot, the rename table and the pointers, and pulses a flush line for the rest of the core.

Top module: `spec_rob`

## Requirements
- R1: After reset the ring is empty: the slot offered is 0, a request with a free reservation station is granted, `rf_we`, `st_we` and `flush` are low, and no register reads as pending.
- R2: `alloc_gnt` is high only while `alloc_req` and `alloc_rs_free` are both high. Granted tags run 0,1,...,DEPTH-1 and then wrap to 0.
- R3: Once DEPTH slots are occupied, `alloc_gnt` stays low.
- R4: A bus write marks its slot complete. Only the oldest slot retires, and only when complete, so a younger complete slot waits for all older ones.
- R5: When an arithmetic entry (kind 0) retires on a clock edge, `rf_we` is high for the following cycle, with that entry's destination on `rf_waddr` and its result on `rf_wdata`.
- R6: When a store (kind 1) retires, `st_we` is high for the following cycle, with the address given at dispatch on `st_addr` and the bus value on `st_wdata`. `rf_we` stays low.
- R7: When a branch (kind 2) whose bus write carried `cdb_mispred`=1 reaches the head complete, it does not retire. The following cycle has a single-cycle `flush`, an empty ring whose next tag is 0, and no pending registers. No grant is given in the cycle of that decision.
- R8: A grant and a retirement in the same cycle leave the occupancy unchanged.
- R9: `look_busy`/`look_tag` give the youngest pending producer of `look_reg`. Retiring a producer clears the entry only if the entry still holds that producer's tag.
- R10: A bus write aimed at an unoccupied slot, or at one already complete, changes nothing.
- R11: A correctly predicted branch retires with no register write, no store and no flush, and its slot is freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Dispatch wants a slot |
| alloc_rs_free | input | 1 | A reservation station is available |
| alloc_kind | input | 2 | 0 arithmetic, 1 store, 2 branch |
| alloc_dreg | input | AREG_W | Destination register (arithmetic) |
| alloc_addr | input | ADDR_W | Memory address (store) |
| alloc_gnt | output | 1 | Slot granted this cycle |
| alloc_tag | output | TAG_W | Slot number offered, used as tag |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Producing slot |
| cdb_value | input | DATA_W | Result or store data |
| cdb_mispred | input | 1 | Branch resolved as mispredicted |
| look_reg | input | AREG_W | Register to look up in the rename table |
| look_busy | output | 1 | Register has a pending producer |
| look_tag | output | TAG_W | Tag of youngest pending producer |
| rf_we | output | 1 | Register-file write |
| rf_waddr | output | AREG_W | Register-file write address |
| rf_wdata | output | DATA_W | Register-file write data |
| st_we | output | 1 | Memory store write |
| st_addr | output | ADDR_W | Store address |
| st_wdata | output | DATA_W | Store data |
| flush | output | 1 | Speculative state discarded |

## Verification
Grant and offered tag are combinational from the current state, so the bench probes them one time unit after setting the request and before the next edge. A bus write lands on the following edge. The retirement decision is taken on the edge after that, and the registered commit and flush outputs are valid in the cycle that follows. The bench therefore samples them on the second falling edge after the bus write is first driven. Slots held back behind an incomplete head are sampled one extra falling edge per older slot, and the single-cycle pulses are confirmed low again one cycle later.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_ALU    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } rob_kind_e;
endpackage

// File: rtl/rob_ptr_ctl.sv
module rob_ptr_ctl #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             commit_fire,
  input  logic             flush_fire,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [OCC_W-1:0] occ,
  output logic             full
);
  logic [TAG_W-1:0] head_d, tail_d;
  logic [OCC_W-1:0] occ_d;

  function automatic logic [TAG_W-1:0] step(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    head_d = head;
    tail_d = tail;
    occ_d  = occ;
    if (flush_fire) begin
      head_d = '0;
      tail_d = '0;
      occ_d  = '0;
    end else begin
      if (alloc_fire)  tail_d = step(tail);
      if (commit_fire) head_d = step(head);
      case ({alloc_fire, commit_fire})
        2'b10:   occ_d = occ + OCC_W'(1);
        2'b01:   occ_d = occ - OCC_W'(1);
        default: occ_d = occ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      head <= head_d;
      tail <= tail_d;
      occ  <= occ_d;
    end
  end

  assign full = (occ == OCC_W'(DEPTH));
endmodule

// File: rtl/rob_entries.sv
module rob_entries
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AREG_W = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_fire,
  input  logic [TAG_W-1:0]  alloc_idx,
  input  rob_kind_e         alloc_kind,
  input  logic [AREG_W-1:0] alloc_dreg,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              cdb_mispred,
  input  logic              free_fire,
  input  logic              flush_fire,
  input  logic [TAG_W-1:0]  head_idx,
  output logic              head_valid,
  output logic              head_done,
  output rob_kind_e         head_kind,
  output logic [AREG_W-1:0] head_dreg,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_value,
  output logic              head_mispred
);
  logic              valid_v [DEPTH];
  logic              done_v  [DEPTH];
  logic              mis_v   [DEPTH];
  rob_kind_e         kind_v  [DEPTH];
  logic [AREG_W-1:0] dreg_v  [DEPTH];
  logic [ADDR_W-1:0] addr_v  [DEPTH];
  logic [DATA_W-1:0] value_v [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              v_q, v_d, d_q, d_d, m_q, m_d;
    rob_kind_e         k_q;
    logic [AREG_W-1:0] r_q;
    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] x_q;
    logic              take_alloc, take_cdb, take_free;

    assign take_alloc = alloc_fire && (alloc_idx == TAG_W'(i));
    assign take_cdb   = cdb_valid && (cdb_tag == TAG_W'(i)) && v_q && !d_q;
    assign take_free  = free_fire && (head_idx == TAG_W'(i));

    always_comb begin
      v_d = v_q;
      d_d = d_q;
      m_d = m_q;
      if (flush_fire) begin
        v_d = 1'b0;
        d_d = 1'b0;
      end else begin
        if (take_free) begin
          v_d = 1'b0;
          d_d = 1'b0;
        end
        if (take_alloc) begin
          v_d = 1'b1;
          d_d = 1'b0;
          m_d = 1'b0;
        end
        if (take_cdb) begin
          d_d = 1'b1;
          m_d = cdb_mispred;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        m_q <= 1'b0;
      end else begin
        v_q <= v_d;
        d_q <= d_d;
        m_q <= m_d;
      end
    end

    always_ff @(posedge clk) begin
      if (take_alloc) begin
        k_q <= alloc_kind;
        r_q <= alloc_dreg;
        a_q <= alloc_addr;
      end
      if (take_cdb) x_q <= cdb_value;
    end

    assign valid_v[i] = v_q;
    assign done_v[i]  = d_q;
    assign mis_v[i]   = m_q;
    assign kind_v[i]  = k_q;
    assign dreg_v[i]  = r_q;
    assign addr_v[i]  = a_q;
    assign value_v[i] = x_q;
  end

  assign head_valid   = valid_v[head_idx];
  assign head_done    = done_v[head_idx];
  assign head_mispred = mis_v[head_idx];
  assign head_kind    = kind_v[head_idx];
  assign head_dreg    = dreg_v[head_idx];
  assign head_addr    = addr_v[head_idx];
  assign head_value   = value_v[head_idx];
endmodule

// File: rtl/rob_rename.sv
module rob_rename #(
  parameter int AREGS = 16,
  parameter int TAG_W = 3,
  localparam int AREG_W = $clog2(AREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [AREG_W-1:0] set_reg,
  input  logic [TAG_W-1:0]  set_tag,
  input  logic              clr_en,
  input  logic [AREG_W-1:0] clr_reg,
  input  logic [TAG_W-1:0]  clr_tag,
  input  logic              wipe,
  input  logic [AREG_W-1:0] look_reg,
  output logic              look_busy,
  output logic [TAG_W-1:0]  look_tag
);
  logic             busy_v [AREGS];
  logic [TAG_W-1:0] tag_v  [AREGS];

  for (genvar r = 0; r < AREGS; r++) begin : g_map
    logic             b_q, b_d;
    logic [TAG_W-1:0] t_q;
    logic             hit_set, hit_clr;

    assign hit_set = set_en && (set_reg == AREG_W'(r));
    assign hit_clr = clr_en && (clr_reg == AREG_W'(r)) && b_q && (t_q == clr_tag);

    always_comb begin
      b_d = b_q;
      if (wipe)         b_d = 1'b0;
      else if (hit_set) b_d = 1'b1;
      else if (hit_clr) b_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) b_q <= 1'b0;
      else        b_q <= b_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       t_q <= '0;
      else if (hit_set) t_q <= set_tag;
    end

    assign busy_v[r] = b_q;
    assign tag_v[r]  = t_q;
  end

  assign look_busy = busy_v[look_reg];
  assign look_tag  = tag_v[look_reg];
endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AREGS  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int AREG_W = $clog2(AREGS),
  localparam int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic              alloc_rs_free,
  input  logic [1:0]        alloc_kind,
  input  logic [AREG_W-1:0] alloc_dreg,
  input  logic [ADDR_W-1:0] alloc_addr,
  output logic              alloc_gnt,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              cdb_mispred,
  input  logic [AREG_W-1:0] look_reg,
  output logic              look_busy,
  output logic [TAG_W-1:0]  look_tag,
  output logic              rf_we,
  output logic [AREG_W-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              st_we,
  output logic [ADDR_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_wdata,
  output logic              flush
);
  logic [TAG_W-1:0]  head, tail;
  logic [OCC_W-1:0]  occ;
  logic              full;
  logic              head_valid, head_done, head_mispred;
  rob_kind_e         head_kind;
  logic [AREG_W-1:0] head_dreg;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_value;
  logic              head_ready, flush_fire, commit_fire;
  logic              rf_we_d, st_we_d;

  assign head_ready  = head_valid && head_done;
  assign flush_fire  = head_ready && (head_kind == KIND_BRANCH) && head_mispred;
  assign commit_fire = head_ready && !flush_fire;
  assign alloc_gnt   = alloc_req && alloc_rs_free && !full && !flush_fire;
  assign alloc_tag   = tail;

  rob_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire  (alloc_gnt),
    .commit_fire (commit_fire),
    .flush_fire  (flush_fire),
    .head        (head),
    .tail        (tail),
    .occ         (occ),
    .full        (full)
  );

  rob_entries #(
    .DEPTH(DEPTH), .AREG_W(AREG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ent (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_fire   (alloc_gnt),
    .alloc_idx    (tail),
    .alloc_kind   (rob_kind_e'(alloc_kind)),
    .alloc_dreg   (alloc_dreg),
    .alloc_addr   (alloc_addr),
    .cdb_valid    (cdb_valid),
    .cdb_tag      (cdb_tag),
    .cdb_value    (cdb_value),
    .cdb_mispred  (cdb_mispred),
    .free_fire    (commit_fire),
    .flush_fire   (flush_fire),
    .head_idx     (head),
    .head_valid   (head_valid),
    .head_done    (head_done),
    .head_kind    (head_kind),
    .head_dreg    (head_dreg),
    .head_addr    (head_addr),
    .head_value   (head_value),
    .head_mispred (head_mispred)
  );

  rob_rename #(.AREGS(AREGS), .TAG_W(TAG_W)) u_ren (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (alloc_gnt && (alloc_kind == KIND_ALU)),
    .set_reg   (alloc_dreg),
    .set_tag   (tail),
    .clr_en    (commit_fire && (head_kind == KIND_ALU)),
    .clr_reg   (head_dreg),
    .clr_tag   (head),
    .wipe      (flush_fire),
    .look_reg  (look_reg),
    .look_busy (look_busy),
    .look_tag  (look_tag)
  );

  assign rf_we_d = commit_fire && (head_kind == KIND_ALU);
  assign st_we_d = commit_fire && (head_kind == KIND_STORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_we <= 1'b0;
      st_we <= 1'b0;
      flush <= 1'b0;
    end else begin
      rf_we <= rf_we_d;
      st_we <= st_we_d;
      flush <= flush_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_waddr <= '0;
      rf_wdata <= '0;
      st_addr  <= '0;
      st_wdata <= '0;
    end else begin
      if (rf_we_d) begin
        rf_waddr <= head_dreg;
        rf_wdata <= head_value;
      end
      if (st_we_d) begin
        st_addr  <= head_addr;
        st_wdata <= head_value;
      end
    end
  end
endmodule

// File: rtl/spec_rob_chk.sv
module spec_rob_chk #(
  parameter int DEPTH = 8,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_req,
  input logic             alloc_rs_free,
  input logic             alloc_gnt,
  input logic             rf_we,
  input logic             st_we,
  input logic             flush,
  input logic [OCC_W-1:0] occ,
  input logic             commit_fire
);
  AST_GNT_NEEDS_RS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt |-> (alloc_req && alloc_rs_free)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OCC_W'(DEPTH)) |-> !alloc_gnt); // R3
  AST_NO_COMMIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !commit_fire); // R4
  AST_SINGLE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && st_we)); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (occ == '0)); // R7
  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush); // R7
  AST_SWAP_KEEPS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_gnt && commit_fire) |=> $stable(occ)); // R8
endmodule

bind spec_rob spec_rob_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .alloc_req     (alloc_req),
  .alloc_rs_free (alloc_rs_free),
  .alloc_gnt     (alloc_gnt),
  .rf_we         (rf_we),
  .st_we         (st_we),
  .flush         (flush),
  .occ           (occ),
  .commit_fire   (commit_fire)
);

// File: tb/test_spec_rob.sv
module test_spec_rob;
  localparam int CLK_P = 20;
  localparam int KALU = 0, KST = 1, KBR = 2;

  logic        clk, rst_n;
  logic        alloc_req, alloc_rs_free;
  logic [1:0]  alloc_kind;
  logic [3:0]  alloc_dreg;
  logic [15:0] alloc_addr;
  logic        alloc_gnt;
  logic [2:0]  alloc_tag;
  logic        cdb_valid;
  logic [2:0]  cdb_tag;
  logic [31:0] cdb_value;
  logic        cdb_mispred;
  logic [3:0]  look_reg;
  logic        look_busy;
  logic [2:0]  look_tag;
  logic        rf_we;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        st_we;
  logic [15:0] st_addr;
  logic [31:0] st_wdata;
  logic        flush;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  spec_rob i_spec_rob (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_rs_free(alloc_rs_free),
    .alloc_kind(alloc_kind), .alloc_dreg(alloc_dreg), .alloc_addr(alloc_addr),
    .alloc_gnt(alloc_gnt), .alloc_tag(alloc_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .cdb_mispred(cdb_mispred),
    .look_reg(look_reg), .look_busy(look_busy), .look_tag(look_tag),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata),
    .flush(flush)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic probe_gnt(output logic g, output logic [2:0] t);
    alloc_req = 1'b1;
    alloc_rs_free = 1'b1;
    #1;
    g = alloc_gnt;
    t = alloc_tag;
    alloc_req = 1'b0;
  endtask

  task automatic do_alloc(input int kind, input int dreg, input int addr, input int exp_tag, input string req);
    alloc_req = 1'b1;
    alloc_rs_free = 1'b1;
    alloc_kind = 2'(kind);
    alloc_dreg = 4'(dreg);
    alloc_addr = 16'(addr);
    #1;
    chk(req, "grant", alloc_gnt, 1);
    chk(req, "tag", alloc_tag, exp_tag);
    @(negedge clk);
    alloc_req = 1'b0;
  endtask

  task automatic do_cdb(input int tag, input longint val, input bit mis);
    cdb_valid = 1'b1;
    cdb_tag = 3'(tag);
    cdb_value = 32'(val);
    cdb_mispred = mis;
    @(negedge clk);
    cdb_valid = 1'b0;
    cdb_mispred = 1'b0;
  endtask

  task automatic look(input int r, input int busy, input int tag, input string req);
    look_reg = 4'(r);
    #1;
    chk(req, "look_busy", look_busy, busy);
    if (busy != 0) chk(req, "look_tag", look_tag, tag);
  endtask

  task automatic t_reset();
    logic g;
    logic [2:0] t;
    chk("R1", "rf_we in reset", rf_we, 0);
    chk("R1", "flush in reset", flush, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    probe_gnt(g, t);
    chk("R1", "grant when empty", g, 1);
    chk("R1", "first tag", t, 0);
    chk("R1", "rf_we", rf_we, 0);
    chk("R1", "st_we", st_we, 0);
    chk("R1", "flush", flush, 0);
    look(5, 0, 0, "R1");
  endtask

  task automatic t_alu_commit();
    do_alloc(KALU, 5, 0, 0, "R2");
    look(5, 1, 0, "R9");
    do_cdb(0, 32'h1234, 0);
    @(negedge clk);
    chk("R5", "rf_we", rf_we, 1);
    chk("R5", "rf_waddr", rf_waddr, 5);
    chk("R5", "rf_wdata", rf_wdata, 32'h1234);
    look(5, 0, 0, "R9");
    @(negedge clk);
    chk("R5", "rf_we pulse end", rf_we, 0);
  endtask

  task automatic t_rs_gate();
    alloc_req = 1'b1;
    alloc_rs_free = 1'b0;
    #1;
    chk("R2", "grant without station", alloc_gnt, 0);
    alloc_req = 1'b0;
    alloc_rs_free = 1'b1;
    #1;
    chk("R2", "grant without request", alloc_gnt, 0);
    @(negedge clk);
  endtask

  task automatic t_in_order();
    do_alloc(KALU, 1, 0, 1, "R2");
    do_alloc(KALU, 2, 0, 2, "R2");
    do_cdb(2, 32'hA, 0);
    chk("R4", "younger waits", rf_we, 0);
    @(negedge clk);
    chk("R4", "younger still waits", rf_we, 0);
    do_cdb(1, 32'hB, 0);
    @(negedge clk);
    chk("R4", "older first we", rf_we, 1);
    chk("R4", "older first addr", rf_waddr, 1);
    chk("R4", "older first data", rf_wdata, 32'hB);
    @(negedge clk);
    chk("R4", "younger next we", rf_we, 1);
    chk("R4", "younger next addr", rf_waddr, 2);
    chk("R4", "younger next data", rf_wdata, 32'hA);
  endtask

  task automatic t_store();
    do_alloc(KST, 0, 16'h0040, 3, "R6");
    do_cdb(3, 32'h55, 0);
    @(negedge clk);
    chk("R6", "st_we", st_we, 1);
    chk("R6", "st_addr", st_addr, 16'h0040);
    chk("R6", "st_wdata", st_wdata, 32'h55);
    chk("R6", "rf_we low", rf_we, 0);
    @(negedge clk);
    chk("R6", "st_we pulse end", st_we, 0);
  endtask

  task automatic t_ignore_cdb();
    do_alloc(KALU, 6, 0, 4, "R10");
    do_alloc(KALU, 3, 0, 5, "R10");
    do_cdb(5, 32'h11, 0);
    do_cdb(5, 32'h99, 0);
    do_cdb(6, 32'h77, 0);
    do_alloc(KALU, 7, 0, 6, "R10");
    do_cdb(4, 32'h22, 0);
    @(negedge clk);
    chk("R10", "head data", rf_wdata, 32'h22);
    @(negedge clk);
    chk("R10", "done entry kept first value", rf_wdata, 32'h11);
    chk("R10", "done entry addr", rf_waddr, 3);
    @(negedge clk);
    chk("R10", "write to empty slot ignored", rf_we, 0);
    do_cdb(6, 32'h33, 0);
    @(negedge clk);
    chk("R10", "later write accepted", rf_wdata, 32'h33);
    chk("R10", "later write addr", rf_waddr, 7);
  endtask

  task automatic t_rename_youngest();
    do_alloc(KALU, 9, 0, 7, "R2");
    do_alloc(KALU, 9, 0, 0, "R2");
    look(9, 1, 0, "R9");
    do_cdb(7, 1, 0);
    @(negedge clk);
    chk("R9", "older commit writes", rf_waddr, 9);
    look(9, 1, 0, "R9");
    do_cdb(0, 2, 0);
    @(negedge clk);
    look(9, 0, 0, "R9");
  endtask

  task automatic t_branch_ok();
    do_alloc(KBR, 0, 0, 1, "R11");
    do_cdb(1, 0, 0);
    @(negedge clk);
    chk("R11", "rf_we", rf_we, 0);
    chk("R11", "st_we", st_we, 0);
    chk("R11", "flush", flush, 0);
    @(negedge clk);
    chk("R11", "flush stays low", flush, 0);
  endtask

  task automatic t_full_swap();
    logic g;
    logic [2:0] t;
    for (int i = 0; i < 8; i++) begin
      int tg;
      tg = (2 + i) % 8;
      do_alloc((tg == 4) ? KBR : KALU, 10, 0, tg, "R3");
    end
    probe_gnt(g, t);
    chk("R3", "grant when full", g, 0);
    do_cdb(2, 32'h20, 0);
    do_cdb(3, 32'h30, 0);
    chk("R8", "commit before swap", rf_wdata, 32'h20);
    do_alloc(KALU, 12, 0, 2, "R8");
    do_alloc(KALU, 12, 0, 3, "R8");
    probe_gnt(g, t);
    chk("R8", "full again after swap", g, 0);
  endtask

  task automatic t_flush();
    logic g;
    logic [2:0] t;
    do_cdb(5, 32'h50, 0);
    do_cdb(4, 0, 1);
    probe_gnt(g, t);
    chk("R7", "no grant in flush cycle", g, 0);
    @(negedge clk);
    chk("R7", "flush pulse", flush, 1);
    chk("R7", "no write on flush", rf_we, 0);
    look(10, 0, 0, "R7");
    look(12, 0, 0, "R7");
    probe_gnt(g, t);
    chk("R7", "grant after flush", g, 1);
    chk("R7", "tag after flush", t, 0);
    @(negedge clk);
    chk("R7", "flush single cycle", flush, 0);
    chk("R7", "younger done not committed", rf_we, 0);
    do_alloc(KALU, 3, 0, 0, "R7");
    look(3, 1, 0, "R7");
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    alloc_req = 1'b0;
    alloc_rs_free = 1'b0;
    alloc_kind = '0;
    alloc_dreg = '0;
    alloc_addr = '0;
    cdb_valid = 1'b0;
    cdb_tag = '0;
    cdb_value = '0;
    cdb_mispred = 1'b0;
    look_reg = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_alu_commit();
    t_rs_gate();
    t_in_order();
    t_store();
    t_ignore_cdb();
    t_rename_youngest();
    t_branch_ok();
    t_full_swap();
    t_flush();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule